// File: doc/BRIEF.md
# Flash Toggle Status Generator

This block produces the status byte that a parallel NOR flash returns while an embedded program or erase is in progress. It follows an operation mode (idle, programming, erasing, erase-suspended, programming inside an erase suspend) and a mask of the sectors picked for erase. From these it decides, on each read, whether to return the array byte or a status byte with two toggle bits. Bit 6 flips on each finished read while the device is busy, so it tells active work apart from suspension. Bit 2 flips on each finished read that lands in a sector picked for erase, so it tells which sectors are affected.

The host pins (chip enable, output enable, write enable, all active low) are brought into the clock domain through two-stage synchronisers. A stub command port arms a target mode and a sector mask. The armed mode takes effect on the next rising edge of write enable, which models the last write pulse of a command sequence. A completion strobe ends the current operation. The array byte comes in on a plain input. Bits 7 and 5 of the status byte are registered copies of two input flags.

Top module: `flash_toggle_status`

## Requirements
- R1: In idle mode every read returns `arr_data` and no completed read changes any toggle bit.
- R2: In modes program (1), erase (2) and suspend-program (4), a status read shows bit 6, and bit 6 inverts after each completed read.
- R3: Bit 2 inverts after each completed read whose sector (the top `SECT_BITS` address bits) is set in the erase mask, in every mode.
- R4: In suspended mode (3), a read of a masked sector returns a status byte whose bit 6 does not change, and a read of an unmasked sector returns `arr_data`.
- R5: In the busy modes, a read of an unmasked sector returns a status byte and leaves bit 2 unchanged.
- R6: A read completes when output enable rises while chip enable is low, or when chip enable rises while output enable is low, with write enable high. Each read counts once.
- R7: `cmd_arm` latches the target mode from `cmd_mode` (0 idle, 1 program, 2 erase, 3 suspended, 4 suspend-program). That mode applies only at the next rising edge of write enable, and reads before that edge are unaffected.
- R8: The erase mask is loaded from `cmd_mask` only when erase (2) is applied from idle. Resuming erase from suspended keeps the current mask.
- R9: `op_done` moves program or erase to idle and clears the mask. It moves suspend-program to suspended and keeps the mask. In idle or suspended it has no effect.
- R10: The status byte is {dq7_in, bit6, dq5_in, 0, 0, bit2, 0, 0}, with bits 7 and 5 taken from flags registered once per clock.
- R11: Reset gives idle mode, an empty mask and both toggle bits at 0.
- R12: Arming with a `cmd_mode` code of 5 to 7 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| addr | input | ADDR_W | Read address; the top SECT_BITS bits select the sector |
| arr_data | input | 8 | Array byte returned when no status is shown |
| cmd_mode | input | 3 | Target mode code for the stub command port |
| cmd_mask | input | 2**SECT_BITS | Sectors to erase, one bit per sector |
| cmd_arm | input | 1 | Latches cmd_mode and cmd_mask as the pending command |
| op_done | input | 1 | One-cycle strobe that ends the current operation |
| dq7_in | input | 1 | Value for status bit 7 |
| dq5_in | input | 1 | Value for status bit 5 |
| dq | output | 8 | Read data: status byte or array byte |

## Verification
The assertions assume that `addr` stays stable from the start of a read until its completion has been detected, which takes about three clocks after the ending pin edge. They also assume that each pin level lasts several clocks, so the synchronisers see every edge. The stimulus holds every pin level and the address for five clocks, and ends each read with only one of the two enables. It raises `op_done` only outside read and write pulses, so commit and completion never fall in the same cycle.

// File: rtl/flash_toggle_status.sv
module flash_toggle_status #(
  parameter int ADDR_W    = 12,
  parameter int SECT_BITS = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ce_n,
  input  logic                      oe_n,
  input  logic                      we_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [7:0]                arr_data,
  input  logic [2:0]                cmd_mode,
  input  logic [(1<<SECT_BITS)-1:0] cmd_mask,
  input  logic                      cmd_arm,
  input  logic                      op_done,
  input  logic                      dq7_in,
  input  logic                      dq5_in,
  output logic [7:0]                dq
);

  localparam int NSECT = 1 << SECT_BITS;

  typedef enum logic [2:0] {
    M_IDLE  = 3'd0,
    M_PROG  = 3'd1,
    M_ERASE = 3'd2,
    M_SUSP  = 3'd3,
    M_SPROG = 3'd4
  } mode_t;

  // pin order in the vectors: {ce, oe, we}
  logic [2:0] pin_m, pin_s, pin_p;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_m <= 3'b111;
      pin_s <= 3'b111;
      pin_p <= 3'b111;
    end else begin
      pin_m <= {ce_n, oe_n, we_n};
      pin_s <= pin_m;
      pin_p <= pin_s;
    end
  end

  wire ce_s = pin_s[2], oe_s = pin_s[1], we_s = pin_s[0];
  wire ce_p = pin_p[2], oe_p = pin_p[1], we_p = pin_p[0];

  wire rd_end  = we_s & ((oe_s & ~oe_p & ~ce_p) | (ce_s & ~ce_p & ~oe_p));
  wire we_rise = we_s & ~we_p;

  mode_t            mode, pend_mode;
  logic             pend_v;
  logic [NSECT-1:0] mask, pend_mask;
  logic             t6, t2, dq7_r, dq5_r;

  wire [SECT_BITS-1:0] sect = addr[ADDR_W-1 -: SECT_BITS];
  wire in_sel  = mask[sect];
  wire busy    = (mode == M_PROG) | (mode == M_ERASE) | (mode == M_SPROG);
  wire commit  = we_rise & pend_v;
  wire show_st = busy | ((mode == M_SUSP) & in_sel);

  assign dq = show_st ? {dq7_r, t6, dq5_r, 2'b00, t2, 2'b00} : arr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_mode <= M_IDLE;
      pend_mask <= '0;
    end else if (cmd_arm && cmd_mode <= 3'd4) begin
      pend_v    <= 1'b1;
      pend_mode <= mode_t'(cmd_mode);
      pend_mask <= cmd_mask;
    end else if (commit) begin
      pend_v    <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= M_IDLE;
      mask <= '0;
    end else if (commit) begin
      mode <= pend_mode;
      if (pend_mode == M_ERASE && mode == M_IDLE) mask <= pend_mask;
      else if (pend_mode == M_IDLE)               mask <= '0;
    end else if (op_done) begin
      case (mode)
        M_PROG, M_ERASE: begin mode <= M_IDLE; mask <= '0; end
        M_SPROG:         mode <= M_SUSP;
        default:         ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t6    <= 1'b0;
      t2    <= 1'b0;
      dq7_r <= 1'b0;
      dq5_r <= 1'b0;
    end else begin
      dq7_r <= dq7_in;
      dq5_r <= dq5_in;
      if (rd_end && busy)   t6 <= ~t6;
      if (rd_end && in_sel) t2 <= ~t2;
    end
  end

  a_r11_idle_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_IDLE) |-> (mask == '0));

  a_r2_busy_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_end && busy) |=> (t6 != $past(t6)));

  a_r4_suspend_static: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_end && mode == M_SUSP) |=> $stable(t6));

  a_r1_idle_no_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_end && mode == M_IDLE) |=> ($stable(t6) && $stable(t2)));

  a_r9_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !commit && (mode == M_PROG || mode == M_ERASE)) |=> (mode == M_IDLE));

  a_r12_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_IDLE || mode == M_PROG || mode == M_ERASE || mode == M_SUSP || mode == M_SPROG));

endmodule

// File: tb/flash_toggle_status_tb.sv
module flash_toggle_status_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [11:0] addr = '0;
  logic [7:0] arr_data = '0, dq;
  logic [2:0] cmd_mode = '0;
  logic [7:0] cmd_mask = '0;
  logic cmd_arm = 1'b0, op_done = 1'b0, dq7_in = 1'b0, dq5_in = 1'b0;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  flash_toggle_status #(.ADDR_W(12), .SECT_BITS(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .arr_data(arr_data), .cmd_mode(cmd_mode), .cmd_mask(cmd_mask),
    .cmd_arm(cmd_arm), .op_done(op_done), .dq7_in(dq7_in), .dq5_in(dq5_in), .dq(dq));

  // fields: kind[31:30] (0 commit, 1 OE read, 2 CE read, 3 done), mode[29:27],
  // mask[26:19], sector[18:16], expected dq[15:8], array byte[7:0]
  localparam int NV = 28;
  localparam logic [31:0] VEC [NV] = '{
    {2'd1,3'd0,8'h00,3'd0,8'h3C,8'h3C}, // R1 idle
    {2'd0,3'd1,8'h00,3'd0,8'h00,8'h00}, // R7 program
    {2'd1,3'd0,8'h00,3'd0,8'h00,8'h11}, // R2
    {2'd2,3'd0,8'h00,3'd1,8'h40,8'h11}, // R2 R6 CE-ended
    {2'd1,3'd0,8'h00,3'd0,8'h00,8'h11}, // R2
    {2'd3,3'd0,8'h00,3'd0,8'h00,8'h00}, // R9
    {2'd1,3'd0,8'h00,3'd2,8'h5A,8'h5A}, // R9 R1
    {2'd0,3'd2,8'h05,3'd0,8'h00,8'h00}, // R8 erase sectors 0,2
    {2'd1,3'd0,8'h00,3'd0,8'h40,8'h22}, // R3
    {2'd1,3'd0,8'h00,3'd1,8'h04,8'h22}, // R5
    {2'd1,3'd0,8'h00,3'd2,8'h44,8'h22}, // R3
    {2'd0,3'd3,8'h00,3'd0,8'h00,8'h00}, // suspend
    {2'd1,3'd0,8'h00,3'd0,8'h00,8'h33}, // R4
    {2'd2,3'd0,8'h00,3'd0,8'h04,8'h33}, // R4 R6
    {2'd1,3'd0,8'h00,3'd1,8'h81,8'h81}, // R4 unmasked
    {2'd0,3'd4,8'h00,3'd0,8'h00,8'h00}, // suspend-program
    {2'd1,3'd0,8'h00,3'd1,8'h00,8'h44}, // R2 R5
    {2'd1,3'd0,8'h00,3'd2,8'h40,8'h44}, // R2 R3
    {2'd3,3'd0,8'h00,3'd0,8'h00,8'h00}, // R9 back to suspend
    {2'd1,3'd0,8'h00,3'd2,8'h04,8'h55}, // R9 R4
    {2'd0,3'd2,8'h00,3'd0,8'h00,8'h00}, // R8 resume keeps mask
    {2'd1,3'd0,8'h00,3'd0,8'h00,8'h66}, // R8
    {2'd3,3'd0,8'h00,3'd0,8'h00,8'h00}, // R9
    {2'd1,3'd0,8'h00,3'd0,8'h99,8'h99}, // R9 mask cleared
    {2'd0,3'd2,8'h80,3'd0,8'h00,8'h00}, // R8 sector 7
    {2'd1,3'd0,8'h00,3'd0,8'h44,8'h77}, // R5
    {2'd1,3'd0,8'h00,3'd7,8'h04,8'h77}, // R3
    {2'd3,3'd0,8'h00,3'd0,8'h00,8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read(input logic [2:0] s, input logic [7:0] a, input bit by_ce,
                         output logic [7:0] got);
    addr = {s, 9'h000}; arr_data = a;
    ce_n = 1'b0; oe_n = 1'b0; wait_clk(5);
    got = dq;
    if (by_ce) begin ce_n = 1'b1; wait_clk(5); oe_n = 1'b1; end
    else       begin oe_n = 1'b1; wait_clk(5); ce_n = 1'b1; end
    wait_clk(5);
  endtask

  task automatic arm(input logic [2:0] m, input logic [7:0] k);
    cmd_mode = m; cmd_mask = k; cmd_arm = 1'b1; wait_clk(1); cmd_arm = 1'b0; wait_clk(1);
  endtask

  task automatic we_pulse();
    we_n = 1'b0; wait_clk(5); we_n = 1'b1; wait_clk(5);
  endtask

  task automatic done_pulse();
    op_done = 1'b1; wait_clk(1); op_done = 1'b0; wait_clk(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R6 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] got;
    wait_clk(4); rst_n = 1'b1; wait_clk(2);
    do_read(3'd0, 8'hC3, 1'b0, got);
    check("R11 reset idle", got, 8'hC3);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      v = VEC[i];
      case (v[31:30])
        2'd0: begin arm(v[29:27], v[26:19]); we_pulse(); end
        2'd3: done_pulse();
        default: begin
          do_read(v[18:16], v[7:0], v[31:30] == 2'd2, got);
          check("R1 R2 R3 R4 R5 table", got, v[15:8]);
        end
      endcase
    end

    // R7: armed program has no effect before the write enable edge
    dq7_in = 1'b1; dq5_in = 1'b1;
    arm(3'd1, 8'h00);
    do_read(3'd1, 8'h6E, 1'b0, got);
    check("R7 before WE edge", got, 8'h6E);
    we_pulse();
    do_read(3'd1, 8'h6E, 1'b0, got);
    check("R10 status layout", got, 8'hE0);
    do_read(3'd1, 8'h6E, 1'b1, got);
    check("R2 R10 second read", got, 8'hA0);
    done_pulse();
    done_pulse();
    do_read(3'd1, 8'h17, 1'b0, got);
    check("R9 done in idle", got, 8'h17);

    // R12: illegal code ignored
    arm(3'd7, 8'hFF);
    we_pulse();
    do_read(3'd0, 8'h2B, 1'b0, got);
    check("R12 illegal mode", got, 8'h2B);

    // R11: reset during erase
    dq7_in = 1'b0; dq5_in = 1'b0;
    arm(3'd2, 8'hFF);
    we_pulse();
    do_read(3'd3, 8'h00, 1'b0, got);
    check("R3 erase before reset", got, 8'h40);
    rst_n = 1'b0; wait_clk(3); rst_n = 1'b1; wait_clk(2);
    do_read(3'd3, 8'h5C, 1'b0, got);
    check("R11 reset clears mode", got, 8'h5C);
    arm(3'd1, 8'h00);
    we_pulse();
    do_read(3'd3, 8'h5C, 1'b0, got);
    check("R11 toggles cleared", got, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule